// File: doc/BRIEF.md
# Transactional Footprint and Conflict Tracker

This block records which cache lines the running hardware transaction has read or written. It keeps them in a small fully associative table, where each entry holds a line tag plus a read bit and a write bit. Every local load or store and every snooped remote access is looked up in the table. When a rule of the transaction is broken, the block sends a one-cycle failure pulse with a cause code to the transaction state controller. A commit or abort strobe empties the table in a single cycle.

The thread state input selects how local accesses are treated. Outside a transaction, accesses are ignored. Inside one, accesses are recorded. When the transaction is suspended, accesses pass through unrecorded, but a store to a line the transaction owns makes the transaction fail. A load from a line the transaction wrote is flagged as a forward hit, so the speculative value can be returned. A rollback-only mode records stores alone and turns off conflict detection. Remote accesses are checked whatever their origin, whether transactional or not.

Top module: `tx_footprint_tracker`

## Requirements
- R1: After reset, `fail_o`, `fail_cause_o` and `fwd_hit_o` are 0. Local accesses while `state_i` is 0 (no transaction) never raise a failure, whatever their memory type.
- R2: While `state_i` is 1 (transactional) and the transaction has not failed, a write-back load or store is recorded against its line (address bits above the line offset). A repeated access to a line already held uses no new entry.
- R3: A write-back access that must record a new line while every entry is in use raises a failure with cause 2 (footprint overflow).
- R4: While `state_i` is 1 or 2 and rollback-only mode is off, a snooped store to a line with its read or write bit set, or a snooped load to a line with its write bit set, raises a failure with cause 1 (conflict). A snoop to any other line raises nothing.
- R5: A local access while `state_i` is 1 with `lcl_wb_i` low (not cacheable write-back) raises a failure with cause 3.
- R6: With `rot_i` high, transactional loads are not recorded, stores are recorded, and snoops never raise a conflict.
- R7: Loads and stores while `state_i` is 2 (suspended) are never recorded in the table.
- R8: A store while `state_i` is 2 to any recorded line raises a failure with cause 4 (suspended store).
- R9: A load while `state_i` is 2 to a line with its write bit set drives `fwd_hit_o` high for one cycle, on the cycle after the load. This happens only if the transaction has not failed.
- R10: All outputs are registered one cycle after the triggering inputs. `fail_o` pulses for exactly one cycle, at most once until the next commit or abort. When several causes occur in the same cycle, the priority is conflict, then cause 3, then cause 2, then cause 4.
- R11: A `commit_i` or `abort_i` strobe clears every entry and the failed flag in one cycle. A local access or snoop in that same cycle is neither recorded nor checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| state_i | input | 2 | Thread state: 0 none, 1 transactional, 2 suspended |
| rot_i | input | 1 | Rollback-only transaction mode |
| lcl_vld_i | input | 1 | Local access valid |
| lcl_we_i | input | 1 | Local access is a store |
| lcl_wb_i | input | 1 | Local access targets cacheable write-back memory |
| lcl_addr_i | input | AW | Local access byte address |
| snp_vld_i | input | 1 | Snooped remote access valid |
| snp_we_i | input | 1 | Snooped access is a store |
| snp_addr_i | input | AW | Snooped access byte address |
| commit_i | input | 1 | Commit strobe, clears the footprint |
| abort_i | input | 1 | Abort strobe, clears the footprint |
| fail_o | output | 1 | One-cycle failure pulse |
| fail_cause_o | output | 3 | Cause code: 1 conflict, 2 overflow, 3 non write-back, 4 suspended store, 0 none |
| fwd_hit_o | output | 1 | Suspended load hit a transactionally written line |

## Verification
The bench runs against a four-entry table with 16-byte lines. A distinct-line sweep is run in both modes, with stores and with loads. It separates the overflow boundary at the fifth line from the quiet fourth line and from rollback-only loads that take no entry. Repeated accesses at other offsets within a held line show that a line is matched by tag alone. The conflict check runs through every combination of local load/store, snoop load/store, rollback-only mode and transactional/suspended state. This separates the read-bit rule from the write-bit rule and shows that conflict detection is off in rollback-only mode. Suspended-state sequences refill the table afterwards, so an entry taken by mistake would show as an early overflow. Simultaneous causes, repeated failures and accesses in the same cycle as a commit check the priority, the single pulse and the clear.

// File: rtl/tx_fp_pkg.sv
package tx_fp_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_TX   = 2'd1,
    TS_SUSP = 2'd2
  } tstate_e;

  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_CONFLICT = 3'd1,
    CAUSE_OVERFLOW = 3'd2,
    CAUSE_NONWB    = 3'd3,
    CAUSE_SUSP_ST  = 3'd4
  } fail_cause_e;
endpackage

// File: rtl/tx_fp_findfree.sv
module tx_fp_findfree #(
  parameter int N = 16
) (
  input  logic [N-1:0] used_i,
  output logic [N-1:0] pick_o,
  output logic         full_o
);
  always_comb begin
    logic found;
    found  = 1'b0;
    pick_o = '0;
    for (int i = 0; i < N; i++) begin
      if (!used_i[i] && !found) begin
        pick_o[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  assign full_o = &used_i;
endmodule

// File: rtl/tx_fp_table.sv
module tx_fp_table #(
  parameter int DEPTH = 16,
  parameter int TW    = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [TW-1:0] lk_tag_i,
  input  logic [TW-1:0] sn_tag_i,
  input  logic          upd_i,
  input  logic          alloc_i,
  input  logic          set_rd_i,
  input  logic          set_wr_i,
  output logic          lk_hit_o,
  output logic          lk_wr_o,
  output logic          sn_rd_o,
  output logic          sn_wr_o,
  output logic          full_o
);
  logic [DEPTH-1:0] valid_q, rd_q, wr_q;
  logic [DEPTH-1:0] lk_match, sn_match, pick;
  logic [TW-1:0]    tag_q [DEPTH];

  tx_fp_findfree #(.N(DEPTH)) u_findfree (
    .used_i (valid_q),
    .pick_o (pick),
    .full_o (full_o)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign lk_match[i] = valid_q[i] && (tag_q[i] == lk_tag_i);
    assign sn_match[i] = valid_q[i] && (tag_q[i] == sn_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        rd_q[i]    <= 1'b0;
        wr_q[i]    <= 1'b0;
        tag_q[i]   <= '0;
      end else if (clr_i) begin
        valid_q[i] <= 1'b0;
        rd_q[i]    <= 1'b0;
        wr_q[i]    <= 1'b0;
      end else if (upd_i && lk_match[i]) begin
        rd_q[i] <= rd_q[i] | set_rd_i;
        wr_q[i] <= wr_q[i] | set_wr_i;
      end else if (alloc_i && pick[i]) begin
        valid_q[i] <= 1'b1;
        tag_q[i]   <= lk_tag_i;
        rd_q[i]    <= set_rd_i;
        wr_q[i]    <= set_wr_i;
      end
    end
  end

  assign lk_hit_o = |lk_match;
  assign lk_wr_o  = |(lk_match & wr_q);
  assign sn_rd_o  = |(sn_match & rd_q);
  assign sn_wr_o  = |(sn_match & wr_q);

  // R2
  no_dup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));

  // R11
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (valid_q == '0));
endmodule

// File: rtl/tx_footprint_tracker.sv
module tx_footprint_tracker
  import tx_fp_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int LINE_BYTES = 128,
  parameter int AW         = 32,
  localparam int OFFW      = $clog2(LINE_BYTES),
  localparam int TW        = AW - OFFW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    state_i,
  input  logic          rot_i,
  input  logic          lcl_vld_i,
  input  logic          lcl_we_i,
  input  logic          lcl_wb_i,
  input  logic [AW-1:0] lcl_addr_i,
  input  logic          snp_vld_i,
  input  logic          snp_we_i,
  input  logic [AW-1:0] snp_addr_i,
  input  logic          commit_i,
  input  logic          abort_i,
  output logic          fail_o,
  output logic [2:0]    fail_cause_o,
  output logic          fwd_hit_o
);
  logic in_tx, in_susp, active, clr;
  logic lk_hit, lk_wr, sn_rd, sn_wr, tbl_full;
  logic tx_acc, track, need_alloc;
  logic conflict, nonwb, ovf, susp_st, fail_det, fwd_d;
  logic failed_q;
  fail_cause_e cause_d, cause_q;
  logic unused_offset;

  assign unused_offset = ^{lcl_addr_i[OFFW-1:0], snp_addr_i[OFFW-1:0]};

  assign in_tx   = (state_i == TS_TX);
  assign in_susp = (state_i == TS_SUSP);
  assign active  = in_tx || in_susp;
  assign clr     = commit_i || abort_i;

  // local transactional access, eligible for recording
  assign tx_acc     = lcl_vld_i && in_tx && !clr && !failed_q;
  assign nonwb      = tx_acc && !lcl_wb_i;
  assign track      = tx_acc && lcl_wb_i && (lcl_we_i || !rot_i);
  assign need_alloc = track && !lk_hit;
  assign ovf        = need_alloc && tbl_full;
  assign susp_st    = lcl_vld_i && in_susp && lcl_we_i && lk_hit;
  assign conflict   = snp_vld_i && active && !rot_i &&
                      (snp_we_i ? (sn_rd || sn_wr) : sn_wr);

  always_comb begin
    if (conflict)     cause_d = CAUSE_CONFLICT;
    else if (nonwb)   cause_d = CAUSE_NONWB;
    else if (ovf)     cause_d = CAUSE_OVERFLOW;
    else if (susp_st) cause_d = CAUSE_SUSP_ST;
    else              cause_d = CAUSE_NONE;
  end

  assign fail_det = !failed_q && !clr && (cause_d != CAUSE_NONE);
  assign fwd_d    = lcl_vld_i && in_susp && !lcl_we_i && lk_wr &&
                    !failed_q && !fail_det && !clr;

  tx_fp_table #(.DEPTH(DEPTH), .TW(TW)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .lk_tag_i (lcl_addr_i[AW-1:OFFW]),
    .sn_tag_i (snp_addr_i[AW-1:OFFW]),
    .upd_i    (track && lk_hit && !fail_det),
    .alloc_i  (need_alloc && !tbl_full && !fail_det),
    .set_rd_i (!lcl_we_i),
    .set_wr_i (lcl_we_i),
    .lk_hit_o (lk_hit),
    .lk_wr_o  (lk_wr),
    .sn_rd_o  (sn_rd),
    .sn_wr_o  (sn_wr),
    .full_o   (tbl_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      failed_q  <= 1'b0;
      fail_o    <= 1'b0;
      cause_q   <= CAUSE_NONE;
      fwd_hit_o <= 1'b0;
    end else begin
      failed_q  <= clr ? 1'b0 : (failed_q || fail_det);
      fail_o    <= fail_det;
      cause_q   <= fail_det ? cause_d : CAUSE_NONE;
      fwd_hit_o <= fwd_d;
    end
  end

  assign fail_cause_o = cause_q;

  // R10
  fail_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o);

  // R9
  fwd_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_hit_o |-> $past(in_susp && lcl_vld_i && !lcl_we_i));

  // R6
  rot_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && fail_cause_o == CAUSE_CONFLICT) |-> !$past(rot_i));

  // R3
  ovf_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && fail_cause_o == CAUSE_OVERFLOW) |-> $past(tbl_full));

  // R5
  nonwb_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && fail_cause_o == CAUSE_NONWB) |-> $past(lcl_vld_i && !lcl_wb_i));
endmodule

// File: tb/tx_footprint_tracker_tb.sv
module tx_footprint_tracker_tb;
  localparam int DEPTH = 4;
  localparam int LB    = 16;
  localparam int AW    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] st = 2'd0;
  logic rot = 1'b0, lv = 1'b0, lwe = 1'b0, lwb = 1'b1;
  logic sv = 1'b0, swe = 1'b0, cm = 1'b0, ab = 1'b0;
  logic [AW-1:0] laddr = '0, saddr = '0;
  logic fail, fwd;
  logic [2:0] cause;
  logic fo, fw;
  logic [2:0] co;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tx_footprint_tracker #(.DEPTH(DEPTH), .LINE_BYTES(LB), .AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .state_i(st), .rot_i(rot),
    .lcl_vld_i(lv), .lcl_we_i(lwe), .lcl_wb_i(lwb), .lcl_addr_i(laddr),
    .snp_vld_i(sv), .snp_we_i(swe), .snp_addr_i(saddr),
    .commit_i(cm), .abort_i(ab),
    .fail_o(fail), .fail_cause_o(cause), .fwd_hit_o(fwd)
  );

  function automatic logic [AW-1:0] la(int line, int off);
    return AW'(line * LB + off);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
    fo = fail; co = cause; fw = fwd;
    lv = 0; sv = 0; cm = 0; ab = 0; lwe = 0; swe = 0; lwb = 1;
  endtask

  task automatic lacc(logic we, logic [AW-1:0] a, logic wb = 1'b1);
    lv = 1; lwe = we; laddr = a; lwb = wb; tick();
  endtask

  task automatic snp(logic we, logic [AW-1:0] a);
    sv = 1; swe = we; saddr = a; tick();
  endtask

  task automatic clear();
    ab = 1; tick();
  endtask

  task automatic chk_fail(string req, logic ef, int ec);
    n_run++;
    if (fo !== ef || int'(co) != ec) begin
      n_fail++;
      $display("FAIL %s: fail/cause got %b/%0d expected %b/%0d", req, fo, co, ef, ec);
    end
  endtask

  task automatic chk_fwd(string req, logic e);
    n_run++;
    if (fw !== e) begin
      n_fail++;
      $display("FAIL %s: fwd_hit got %b expected %b", req, fw, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1; fo = fail; co = cause; fw = fwd;
    // R1 reset state
    chk_fail("R1 reset", 0, 0);
    chk_fwd("R1 reset", 0);
    // R1 no transaction: non-wb store ignored
    lacc(1, la(1, 0), 0); chk_fail("R1 idle nonwb", 0, 0);
    lacc(1, la(2, 0));    chk_fail("R1 idle store", 0, 0);

    // R3 / R10 overflow boundary sweep, both modes, stores
    st = 2'd1;
    for (int r = 0; r < 2; r++) begin
      rot = r[0]; clear();
      for (int i = 0; i <= DEPTH + 1; i++) begin
        lacc(1, la(40 + i, i));
        chk_fail(i == DEPTH ? "R3 overflow" : "R10 no pulse", i == DEPTH, i == DEPTH ? 2 : 0);
      end
    end
    // R6 rot loads take no entry
    rot = 1; clear();
    for (int i = 0; i <= DEPTH + 1; i++) begin
      lacc(0, la(60 + i, 0)); chk_fail("R6 rot load", 0, 0);
    end
    // R2 same-line reuse
    rot = 0; clear();
    for (int i = 0; i < DEPTH; i++) lacc(1, la(i, 0));
    for (int i = 0; i < DEPTH; i++) begin
      lacc(0, la(i, 7 + i)); chk_fail("R2 same line", 0, 0);
    end

    // R4 / R6 conflict matrix
    for (int s = 1; s <= 2; s++)
      for (int r = 0; r < 2; r++)
        for (int lw = 0; lw < 2; lw++)
          for (int sw = 0; sw < 2; sw++) begin
            bit rec, exp;
            st = 2'd1; rot = r[0]; clear();
            lacc(lw[0], la(3, 0));
            st = s[1:0];
            snp(1'b0, la(9, 0)); chk_fail("R4 snoop miss", 0, 0);
            snp(sw[0], la(3, 5));
            rec = (lw == 1) || (r == 0);
            exp = (r == 0) && rec && (sw == 1 || lw == 1);
            chk_fail(r == 1 ? "R6 rot no conflict" : "R4 conflict", exp, exp ? 1 : 0);
          end

    // R5 non write-back inside transaction
    st = 2'd1; rot = 0; clear();
    lacc(0, la(5, 0), 0); chk_fail("R5 nonwb", 1, 3);
    rot = 1; clear();
    lacc(0, la(5, 0), 0); chk_fail("R5 nonwb rot", 1, 3);
    rot = 0;

    // R7 / R9 suspended passthrough and forwarding
    clear();
    lacc(1, la(1, 0)); lacc(0, la(2, 0));
    st = 2'd2;
    lacc(0, la(1, 3)); chk_fwd("R9 written line", 1);
    lacc(0, la(2, 0)); chk_fwd("R9 read-only line", 0);
    lacc(0, la(9, 0)); chk_fwd("R9 untracked", 0);
    lacc(1, la(9, 0)); chk_fail("R7 susp store new line", 0, 0);
    for (int i = 0; i < 4; i++) begin
      lacc(i[0], la(10 + i, 0)); chk_fail("R7 susp passthrough", 0, 0);
    end
    st = 2'd1;
    snp(1, la(9, 0)); chk_fail("R7 not recorded", 0, 0);
    lacc(1, la(20, 0)); chk_fail("R7 fill", 0, 0);
    lacc(1, la(21, 0)); chk_fail("R7 fill", 0, 0);
    lacc(1, la(22, 0)); chk_fail("R7 overflow at depth", 1, 2);

    // R8 suspended store to tracked line, then R9 after failure
    clear();
    lacc(1, la(1, 0)); lacc(0, la(2, 0));
    st = 2'd2;
    lacc(1, la(2, 4)); chk_fail("R8 susp store", 1, 4);
    lacc(0, la(1, 0)); chk_fwd("R9 after fail", 0);

    // R10 priority and single pulse
    st = 2'd1; clear();
    lacc(0, la(1, 0));
    lv = 1; lwe = 1; lwb = 0; laddr = la(6, 0);
    sv = 1; swe = 1; saddr = la(1, 0);
    tick(); chk_fail("R10 priority", 1, 1);
    snp(1, la(1, 0)); chk_fail("R10 sticky", 0, 0);
    clear();
    lacc(0, la(1, 0)); snp(1, la(1, 0)); chk_fail("R10 rearm", 1, 1);

    // R11 commit clears and same-cycle access ignored
    clear();
    for (int i = 0; i < DEPTH; i++) lacc(1, la(i, 0));
    cm = 1; lv = 1; lwe = 1; laddr = la(8, 0);
    tick(); chk_fail("R11 commit cycle", 0, 0);
    snp(1, la(0, 0)); chk_fail("R11 cleared", 0, 0);
    for (int i = 0; i < DEPTH; i++) begin
      lacc(1, la(30 + i, 0)); chk_fail("R11 refill", 0, 0);
    end
    snp(0, la(8, 0)); chk_fail("R11 ignored access", 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule